// File: doc/BRIEF.md
# Two-Wire Serial Register-Access Slave

This block lets an external bus master read and write a 256-entry, 8-bit register file over a two-wire serial bus made of a clock line and a data line. A fast system clock oversamples both lines through two-flop synchronisers. The block finds start, repeated-start and stop conditions, takes a 7-bit device address with a direction bit, and then moves register data in either direction. It never drives the data line high. It only asserts an output enable that pulls the line low, and the pad logic outside the block turns that enable into the open-drain drive.

An 8-bit register pointer selects the register that is accessed. The pointer advances after every data byte, wraps from FFH back to 00H, and keeps its value from one transaction to the next. Three transfer shapes are supported:

- A write: device address, register address, then any number of data bytes.
- A current-address read: device address with the read flag, then data from the pointer.
- A random read: a write that sends only a register address, then a repeated start and a read.

Top module: `regslave_top`

## Requirements
- R1: After reset, the data-line output enable is low, the register pointer is 00H and every register holds 00H.
- R2: The slave acknowledges an address byte whose upper 7 bits equal the parameter DEV_ADDR (default 5AH) by holding the data line low during the ninth clock. For any other address it leaves the line released and ignores all traffic until the next start or stop. Bytes sent after a mismatched address modify no register.
- R3: In a write (address byte LSB = 0), the byte after the address byte is the register address. Each following byte is stored at the pointer, the pointer then advances, and every byte receives an acknowledge.
- R4: Within one burst, whether write or read, the pointer wraps from FFH to 00H.
- R5: A read (address byte LSB = 1) with no register-address phase returns data MSB first, starting at the current pointer. The pointer value carries over from earlier transactions.
- R6: A write that sends only a register address, followed by a repeated start and a read address byte, returns data starting at that register.
- R7: During a read, a master acknowledge (line low in the ninth clock) requests the next consecutive register. A master not-acknowledge makes the slave stop driving the line. In both cases the pointer has already advanced past the last byte sent.
- R8: A start is the data line falling while the clock line is high. A stop is the data line rising while the clock line is high. Both release the output enable. Apart from these events, the output enable changes only after a falling clock edge has been detected, so it is stable while the clock is high.
- R9: A register-address byte loads the pointer even when a stop follows it with no data bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level (wired-AND of all drivers) |
| sdaOe | output | 1 | High pulls the data line low |

## Verification
The bench targets three corner cases:

- **Pointer wrap across FFH.** A burst that crosses FFH in both directions exposes a pointer that saturates or carries into a wider value; such a design would return or overwrite the wrong register.
- **Pointer after the last byte.** A current-address read right after a NACKed read, and right after an address-only write, shows whether the pointer moved past the last byte and whether a bare register address loaded it. A design that advances only on a master ACK, or loads the pointer only with data, returns an off-by-one register.
- **Mismatched device address.** A write to a wrong device address, followed by a read-back of the targeted register, catches a slave that acknowledges or stores foreign traffic.

Data-line stability during every high clock phase of every read is also watched, since a slave that updates on rising edges would corrupt the data the master samples.

// File: rtl/regslave_pkg.sv
package regslave_pkg;
  // strobes from control to datapath; at most one action per cycle besides shiftRx
  typedef struct packed {
    logic shiftRx;
    logic loadPtr;
    logic writeReg;
    logic loadTx;
    logic shiftTx;
    logic driveAck;
    logic relOe;
  } dpCmd_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEVADDR, ST_REGADDR, ST_WDATA, ST_RDATA, ST_IGNORE
  } phase_t;
endpackage

// File: rtl/regslave_sync.sv
module regslave_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclRaw,
  input  logic sdaRaw,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);
  logic [STAGES:0] sclPipe;
  logic [STAGES:0] sdaPipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[STAGES-1:0], sclRaw};
      sdaPipe <= {sdaPipe[STAGES-1:0], sdaRaw};
    end
  end

  logic sclNow, sclOld, sdaNow, sdaOld;
  assign sclNow = sclPipe[STAGES-1];
  assign sclOld = sclPipe[STAGES];
  assign sdaNow = sdaPipe[STAGES-1];
  assign sdaOld = sdaPipe[STAGES];

  assign sdaLvl  = sdaNow;
  assign sclRise = sclNow & ~sclOld;
  assign sclFall = ~sclNow & sclOld;
  assign startEv = sclNow & sclOld & sdaOld & ~sdaNow;
  assign stopEv  = sclNow & sclOld & ~sdaOld & sdaNow;
endmodule

// File: rtl/regslave_ctrl.sv
module regslave_ctrl
  import regslave_pkg::*;
#(
  parameter int         DATA_W   = 8,
  parameter logic [6:0] DEV_ADDR = 7'h5A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaLvl,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startEv,
  input  logic              stopEv,
  input  logic [DATA_W-1:0] rxNext,
  output dpCmd_t            cmd
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LASTB = CNT_W'(DATA_W - 1);

  phase_t           state;
  logic [CNT_W-1:0] bitCnt;
  logic             ackPhase;
  logic             rwFlag;
  logic             mAck;

  logic rxState, active, byteEnd, devMatch;
  assign rxState  = (state == ST_DEVADDR) || (state == ST_REGADDR) || (state == ST_WDATA);
  assign active   = (state != ST_IDLE) && (state != ST_IGNORE);
  assign byteEnd  = sclRise && rxState && !ackPhase && (bitCnt == LASTB);
  assign devMatch = (rxNext[DATA_W-1:DATA_W-7] == DEV_ADDR);

  always_comb begin
    cmd = '0;
    if (startEv || stopEv) begin
      cmd.relOe = 1'b1;
    end else if (sclRise) begin
      if (rxState && !ackPhase && (bitCnt < FULL)) cmd.shiftRx = 1'b1;
      if (byteEnd && state == ST_REGADDR) cmd.loadPtr  = 1'b1;
      if (byteEnd && state == ST_WDATA)   cmd.writeReg = 1'b1;
    end else if (sclFall && active) begin
      if (!ackPhase && state == ST_RDATA && bitCnt != '0 && bitCnt < FULL) begin
        cmd.shiftTx = 1'b1;
      end else if (!ackPhase && bitCnt == FULL) begin
        if (state == ST_RDATA) cmd.relOe = 1'b1;
        else                   cmd.driveAck = 1'b1;
      end else if (ackPhase) begin
        if ((state == ST_RDATA && mAck) || (state == ST_DEVADDR && rwFlag))
          cmd.loadTx = 1'b1;
        else
          cmd.relOe = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackPhase <= 1'b0;
      rwFlag   <= 1'b0;
      mAck     <= 1'b0;
    end else if (startEv) begin
      state    <= ST_DEVADDR;
      bitCnt   <= '0;
      ackPhase <= 1'b0;
    end else if (stopEv) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackPhase <= 1'b0;
    end else if (sclRise && active) begin
      if (!ackPhase) begin
        if (bitCnt < FULL) bitCnt <= bitCnt + 1'b1;
        if (byteEnd && state == ST_DEVADDR) begin
          rwFlag <= rxNext[0];
          if (!devMatch) state <= ST_IGNORE;
        end
      end else begin
        mAck <= ~sdaLvl;
      end
    end else if (sclFall && active) begin
      if (!ackPhase && bitCnt == FULL) begin
        ackPhase <= 1'b1;
      end else if (ackPhase) begin
        ackPhase <= 1'b0;
        bitCnt   <= '0;
        unique case (state)
          ST_DEVADDR: state <= rwFlag ? ST_RDATA : ST_REGADDR;
          ST_REGADDR: state <= ST_WDATA;
          ST_RDATA:   state <= mAck ? ST_RDATA : ST_IGNORE;
          default:    state <= state;
        endcase
      end
    end
  end
endmodule

// File: rtl/regslave_dp.sv
module regslave_dp
  import regslave_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaLvl,
  input  dpCmd_t            cmd,
  output logic [DATA_W-1:0] rxNext,
  output logic [ADDR_W-1:0] ptr,
  output logic              sdaOe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int MSB   = DATA_W - 1;

  logic [DATA_W-1:0] regs [DEPTH];
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rdWord;

  assign rxNext = {rxShift[MSB-1:0], sdaLvl};
  assign rdWord = regs[ptr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
      rxShift <= '0;
      txShift <= '0;
      ptr     <= '0;
      sdaOe   <= 1'b0;
    end else begin
      if (cmd.shiftRx) rxShift <= rxNext;
      if (cmd.loadPtr) ptr <= rxNext[ADDR_W-1:0];
      if (cmd.writeReg) begin
        regs[ptr] <= rxNext;
        ptr       <= ptr + 1'b1;
      end
      if (cmd.loadTx) begin
        txShift <= rdWord;
        sdaOe   <= ~rdWord[MSB];
        ptr     <= ptr + 1'b1;
      end
      if (cmd.shiftTx) begin
        txShift <= txShift << 1;
        sdaOe   <= ~txShift[MSB-1];
      end
      if (cmd.driveAck) sdaOe <= 1'b1;
      if (cmd.relOe)    sdaOe <= 1'b0;
    end
  end
endmodule

// File: rtl/regslave_top.sv
module regslave_top
  import regslave_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter int         DATA_W   = 8,
  parameter int         STAGES   = 2,
  parameter logic [6:0] DEV_ADDR = 7'h5A
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe
);
  logic              sdaLvl, sclRise, sclFall, startEv, stopEv;
  dpCmd_t            cmd;
  logic [DATA_W-1:0] rxNext;
  logic [ADDR_W-1:0] ptr;

  regslave_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclRaw(sclIn), .sdaRaw(sdaIn),
    .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv)
  );

  regslave_ctrl #(.DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sdaLvl(sdaLvl), .sclRise(sclRise),
    .sclFall(sclFall), .startEv(startEv), .stopEv(stopEv),
    .rxNext(rxNext), .cmd(cmd)
  );

  regslave_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .sdaLvl(sdaLvl), .cmd(cmd),
    .rxNext(rxNext), .ptr(ptr), .sdaOe(sdaOe)
  );
endmodule

// File: rtl/regslave_chk.sv
module regslave_chk
  import regslave_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sdaOe,
  input logic              sclFall,
  input logic              startEv,
  input logic              stopEv,
  input dpCmd_t            cmd,
  input logic [DATA_W-1:0] rxNext,
  input logic [ADDR_W-1:0] ptr
);
  assert_oe_after_fall_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> ($past(sclFall) || $past(startEv) || $past(stopEv)));

  assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> !sdaOe);

  assert_start_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    startEv |=> !sdaOe);

  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.writeReg || cmd.loadTx) |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));

  assert_ptr_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmd.loadPtr |=> (ptr == $past(rxNext[ADDR_W-1:0])));

  assert_one_action_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.loadPtr, cmd.writeReg, cmd.loadTx, cmd.shiftTx, cmd.driveAck, cmd.relOe}));
endmodule

bind regslave_top regslave_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .sclFall(sclFall),
  .startEv(startEv), .stopEv(stopEv), .cmd(cmd), .rxNext(rxNext), .ptr(ptr)
);

// File: tb/regslave_top_tb.sv
module regslave_top_tb;
  localparam logic [6:0] DEV = 7'h5A;
  localparam int Q = 10;
  localparam int H = 10;
  localparam int LIMIT = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic sdaOe;
  logic sdaLine;
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;

  logic [7:0] model [256];
  logic [7:0] mPtr;

  always #2 clk = ~clk;
  assign sdaLine = mSda & ~sdaOe;

  regslave_top u_dut (.clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .sdaOe(sdaOe));

  always @(posedge clk) begin
    cyc++;
    if (cyc == LIMIT) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] expRead(input logic [7:0] a);
    return model[a];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clockBit(input logic drv, output logic s0, output logic s1);
    mSda = drv;
    waitN(Q);
    mScl = 1'b1;
    waitN(H);
    s0 = sdaLine;
    waitN(H);
    s1 = sdaLine;
    mScl = 1'b0;
    waitN(Q);
  endtask

  task automatic startCond();
    mSda = 1'b1; waitN(Q);
    mScl = 1'b1; waitN(Q);
    mSda = 1'b0; waitN(Q);
    mScl = 1'b0; waitN(Q);
  endtask

  task automatic stopCond();
    mSda = 1'b0; waitN(Q);
    mScl = 1'b1; waitN(Q);
    mSda = 1'b1; waitN(Q);
  endtask

  task automatic writeByte(input logic [7:0] b, output bit ack);
    logic s0, s1;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s0, s1);
    clockBit(1'b1, s0, s1);
    ack = !s1;
  endtask

  task automatic readByte(input bit ackIt, output logic [7:0] b, output bit stable);
    logic s0, s1;
    stable = 1;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s0, s1);
      b[i] = s1;
      if (s0 !== s1) stable = 0;
    end
    clockBit(ackIt ? 1'b0 : 1'b1, s0, s1);
  endtask

  task automatic txWrite(input logic [6:0] dev, input logic [7:0] addr,
                         input logic [7:0] d0, input logic [7:0] d1,
                         input logic [7:0] d2, input logic [7:0] d3, input int n);
    bit ack;
    logic [7:0] dat [4];
    dat[0] = d0; dat[1] = d1; dat[2] = d2; dat[3] = d3;
    startCond();
    writeByte({dev, 1'b0}, ack);
    if (dev == DEV) chk(ack, "R2 address ack", ack, 1);
    else            chk(!ack, "R2 mismatch no ack", ack, 0);
    writeByte(addr, ack);
    if (dev == DEV) begin
      chk(ack, "R3 regaddr ack", ack, 1);
      mPtr = addr;
    end else chk(!ack, "R2 ignored regaddr", ack, 0);
    for (int i = 0; i < n; i++) begin
      writeByte(dat[i], ack);
      if (dev == DEV) begin
        chk(ack, "R3 data ack", ack, 1);
        model[mPtr] = dat[i];
        mPtr = mPtr + 8'd1;
      end else chk(!ack, "R2 ignored data", ack, 0);
    end
    stopCond();
  endtask

  task automatic readBurst(input int n, input string tag);
    logic [7:0] b;
    bit st;
    for (int i = 0; i < n; i++) begin
      readByte(i != n - 1, b, st);
      chk(b == expRead(mPtr), tag, b, expRead(mPtr));
      chk(st, "R8 line stable while clock high", st, 1);
      mPtr = mPtr + 8'd1;
    end
    waitN(2);
    chk(sdaOe == 1'b0, "R7 released after nack", sdaOe, 0);
  endtask

  task automatic txCurRead(input int n, input string tag);
    bit ack;
    startCond();
    writeByte({DEV, 1'b1}, ack);
    chk(ack, "R5 read address ack", ack, 1);
    readBurst(n, tag);
    stopCond();
  endtask

  task automatic txRandRead(input logic [7:0] addr, input int n, input string tag);
    bit ack;
    startCond();
    writeByte({DEV, 1'b0}, ack);
    chk(ack, "R6 address ack", ack, 1);
    writeByte(addr, ack);
    chk(ack, "R6 regaddr ack", ack, 1);
    mPtr = addr;
    startCond();
    writeByte({DEV, 1'b1}, ack);
    chk(ack, "R6 repeated start ack", ack, 1);
    readBurst(n, tag);
    stopCond();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    mPtr = 8'h00;
    void'($urandom(32'd4711));
    waitN(5);
    chk(sdaOe == 1'b0, "R1 oe low in reset", sdaOe, 0);
    rstN = 1'b1;
    waitN(5);
    chk(sdaOe == 1'b0, "R1 oe low after reset", sdaOe, 0);

    txCurRead(2, "R1 R5 reset contents at pointer 0");

    txWrite(DEV, 8'h20, 8'hA1, 8'hB2, 8'hC3, 8'h00, 3);
    txRandRead(8'h20, 3, "R6 R3 random read of burst");
    txCurRead(1, "R7 pointer past last nacked byte");

    txWrite(DEV, 8'hFE, 8'h11, 8'h22, 8'h33, 8'h44, 4);
    txRandRead(8'hFF, 3, "R4 read wraps FF to 00");
    txRandRead(8'h00, 2, "R4 write wrapped into 00");

    txWrite(7'h5B, 8'h20, 8'h55, 8'h66, 8'h00, 8'h00, 2);
    txRandRead(8'h20, 2, "R2 mismatched write ignored");

    txWrite(DEV, 8'h21, 8'h00, 8'h00, 8'h00, 8'h00, 0);
    txCurRead(2, "R9 bare regaddr loads pointer");

    for (int t = 0; t < 25; t++) begin
      int kind, n;
      logic [7:0] a;
      kind = int'($urandom_range(0, 2));
      n    = int'($urandom_range(1, 4));
      a    = 8'($urandom);
      case (kind)
        0: txWrite(DEV, a, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), n);
        1: txRandRead(a, n, "R6 random read");
        default: txCurRead(n, "R5 current read");
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule